// File: doc/BRIEF.md
# Serial Command Frame Decoder for a Dual-Wiper Register Device

This block sits behind the serial pins of a device that holds two six-bit wiper registers, each with four data registers beside it. It receives chip-select framed SPI commands (mode 0, most-significant bit first), checks that the leading identification byte is meant for this device, and splits the instruction byte into an operation, a data-register index and a wiper select. It then either collects a data byte, returns one, or ends the frame at once. The result is a one-cycle command strobe with its operands, sent to a separate register bank.

For reads, the block drives the held operands and a source flag toward the bank. It takes back the bank's six-bit read data, or the bank's busy flag for a status read, and shifts that value out on the serial output. The serial output enable is raised only while a read data byte is being shifted out. The pad drives high impedance whenever the enable is low. The serial pins are sampled by the block's own clock, which must run well above the serial clock rate.

Top module: `scf_frame_decoder`

## Requirements
- R1: A frame proceeds past its first byte only if that byte has bits 7:4 equal to 4'b0101, bits 3:2 equal to zero, and bits 1:0 equal to the `dev_addr` pins.
- R2: When the first byte does not match, the frame issues no command and `so_oe` stays low until chip select rises again.
- R3: In the second byte, bits 7:4 hold the opcode, bits 3:2 the data-register index and bit 0 the wiper select. These values appear on `cmd_dr` and `cmd_wiper`. If bit 1 is one, the whole instruction is ignored.
- R4: Opcode 1010 (write wiper) issues `cmd_kind` 0 and opcode 1100 (write data register) issues `cmd_kind` 1. Each issues exactly one command after the third byte, with `cmd_data` equal to bits 5:0 of that byte. Bits 7:6 of the third byte have no effect.
- R5: The transfer opcodes issue exactly one command as soon as the instruction byte ends, and any later bytes are ignored. The codes are: 1101 gives `cmd_kind` 2, 1110 gives 3, 0001 gives 4 and 1000 gives 5.
- R6: Opcode 1001 (read wiper) and opcode 1011 (read data register) shift out {2'b00, `rd_data`} most-significant bit first in the third byte. Each bit changes only after a falling SCK edge. `rd_from_dr` is 1 for the data-register read and 0 for the wiper read.
- R7: Opcode 0101 (read status) shifts out {7'b0, `wr_busy`} in the third byte.
- R8: `so_oe` is high only during the third byte of a read or status frame. While `so_oe` is low, `so_bit` is 0.
- R9: If chip select rises before a byte is complete, that byte issues no command.
- R10: The opcodes 0000, 0011, 0100, 0110, 0111, 1111 issue no command and leave `so_oe` low for the rest of the frame.
- R11: After opcode 0010, every later SCK rising edge in the frame issues a step command with `cmd_kind` 6. `cmd_up` equals the SI bit sampled at that edge: 1 steps up, 0 steps down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, which samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip select; a high level ends the frame |
| si | input | 1 | Serial data in |
| dev_addr | input | 2 | Strapped device address pins |
| rd_data | input | DW (6) | Bank read value for the selected register |
| wr_busy | input | 1 | Bank flag: nonvolatile write in progress |
| so_bit | output | 1 | Serial data out value |
| so_oe | output | 1 | Serial output enable; low means the pad is high impedance |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_kind | output | 3 | Command code (0..6, see R4, R5, R11) |
| cmd_dr | output | 2 | Held data-register index |
| cmd_wiper | output | 1 | Held wiper select |
| cmd_data | output | DW (6) | Write value |
| cmd_up | output | 1 | Step direction, 1 means up |
| rd_from_dr | output | 1 | Read source: 1 selects a data register, 0 selects a wiper |

## Verification
The pins pass through one register stage, and the SCK edge is detected on the next stage. As a result, a command strobe appears two block-clock edges after the SCK rising edge that completes its byte. A serial output bit changes two edges after an SCK falling edge. The bench holds each SCK phase for four block clocks and records every strobe in a monitor. It compares strobe counts and fields only after chip select has risen. It reads the serial output just before each rising SCK edge, where the value is settled. The bench sweeps all sixteen opcodes and every pairing of identification address with pin strapping, and it computes the expected values from a small bank model of its own.

// File: rtl/scf_pkg.sv
package scf_pkg;

  typedef enum logic [2:0] {
    FS_ID, FS_INS, FS_DATA, FS_STEP, FS_DONE
  } fstate_t;

  typedef enum logic [3:0] {
    OC_NONE, OC_RD_WIPER, OC_WR_WIPER, OC_RD_DREG, OC_WR_DREG,
    OC_D2W, OC_W2D, OC_ALL_D2W, OC_ALL_W2D, OC_STEP, OC_STATUS
  } opclass_t;

  typedef enum logic [2:0] {
    CK_WR_WIPER = 3'd0,
    CK_WR_DREG  = 3'd1,
    CK_D2W      = 3'd2,
    CK_W2D      = 3'd3,
    CK_ALL_D2W  = 3'd4,
    CK_ALL_W2D  = 3'd5,
    CK_STEP     = 3'd6
  } cmdkind_t;

  // Identification byte: type nibble, two zero bits, strapped address.
  function automatic logic id_match(input logic [7:0] b, input logic [3:0] idn,
                                    input logic [1:0] pins);
    return (b[7:4] == idn) && (b[3:2] == 2'b00) && (b[1:0] == pins);
  endfunction

  function automatic opclass_t classify(input logic [7:0] ins);
    opclass_t c;
    case (ins[7:4])
      4'b1001: c = OC_RD_WIPER;
      4'b1010: c = OC_WR_WIPER;
      4'b1011: c = OC_RD_DREG;
      4'b1100: c = OC_WR_DREG;
      4'b1101: c = OC_D2W;
      4'b1110: c = OC_W2D;
      4'b0001: c = OC_ALL_D2W;
      4'b1000: c = OC_ALL_W2D;
      4'b0010: c = OC_STEP;
      4'b0101: c = OC_STATUS;
      default: c = OC_NONE;
    endcase
    if (ins[1]) c = OC_NONE;
    return c;
  endfunction

  function automatic logic is_xfer(input opclass_t c);
    return (c == OC_D2W) || (c == OC_W2D) || (c == OC_ALL_D2W) || (c == OC_ALL_W2D);
  endfunction

  function automatic logic is_read(input opclass_t c);
    return (c == OC_RD_WIPER) || (c == OC_RD_DREG) || (c == OC_STATUS);
  endfunction

  function automatic logic is_write(input opclass_t c);
    return (c == OC_WR_WIPER) || (c == OC_WR_DREG);
  endfunction

  function automatic cmdkind_t kind_of(input opclass_t c);
    cmdkind_t k;
    case (c)
      OC_WR_WIPER: k = CK_WR_WIPER;
      OC_WR_DREG:  k = CK_WR_DREG;
      OC_D2W:      k = CK_D2W;
      OC_W2D:      k = CK_W2D;
      OC_ALL_D2W:  k = CK_ALL_D2W;
      OC_ALL_W2D:  k = CK_ALL_W2D;
      default:     k = CK_STEP;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/scf_pin_sync.sv
module scf_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  output logic cs_q,
  output logic si_q,
  output logic rise_evt,
  output logic fall_evt
);
  logic sck_q, sck_qq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      sck_qq <= 1'b0;
      cs_q   <= 1'b1;
      si_q   <= 1'b0;
    end else begin
      sck_q  <= sck;
      sck_qq <= sck_q;
      cs_q   <= cs_n;
      si_q   <= si;
    end
  end

  assign rise_evt = sck_q & ~sck_qq & ~cs_q;
  assign fall_evt = ~sck_q & sck_qq & ~cs_q;
endmodule

// File: rtl/scf_rx.sv
module scf_rx #(
  parameter int BW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_q,
  input  logic                  si_q,
  input  logic                  rise_evt,
  output logic                  byte_done,
  output logic [BW-1:0]         byte_val,
  output logic [$clog2(BW)-1:0] bit_idx
);
  localparam int CW = $clog2(BW);
  localparam logic [CW-1:0] LAST = CW'(BW - 1);

  logic [BW-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      bit_idx <= '0;
    end else if (cs_q) begin
      bit_idx <= '0;
    end else if (rise_evt) begin
      sh      <= byte_val;
      bit_idx <= bit_idx + 1'b1;
    end
  end

  assign byte_val  = {sh[BW-2:0], si_q};
  assign byte_done = rise_evt && (bit_idx == LAST);
endmodule

// File: rtl/scf_ctrl.sv
module scf_ctrl
  import scf_pkg::*;
#(
  parameter int         DW      = 6,
  parameter int         BW      = 8,
  parameter logic [3:0] ID_CODE = 4'b0101
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_q,
  input  logic          si_q,
  input  logic          rise_evt,
  input  logic          byte_done,
  input  logic [BW-1:0] byte_val,
  input  logic [1:0]    dev_addr,
  output logic          cmd_valid,
  output logic [2:0]    cmd_kind,
  output logic [1:0]    cmd_dr,
  output logic          cmd_wiper,
  output logic [DW-1:0] cmd_data,
  output logic          cmd_up,
  output logic          in_read,
  output logic          rd_from_dr,
  output logic          rd_status,
  output logic          id_fail
);
  fstate_t  state;
  opclass_t cls;
  opclass_t ins_cls;

  assign ins_cls    = classify(byte_val);
  assign id_fail    = byte_done && (state == FS_ID) && !id_match(byte_val, ID_CODE, dev_addr);
  assign in_read    = (state == FS_DATA) && is_read(cls);
  assign rd_from_dr = (cls == OC_RD_DREG);
  assign rd_status  = (cls == OC_STATUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= FS_ID;
      cls       <= OC_NONE;
      cmd_valid <= 1'b0;
      cmd_kind  <= 3'd0;
      cmd_dr    <= 2'd0;
      cmd_wiper <= 1'b0;
      cmd_data  <= '0;
      cmd_up    <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      if (cs_q) begin
        state <= FS_ID;
      end else if (rise_evt) begin
        case (state)
          FS_ID: if (byte_done) state <= id_fail ? FS_DONE : FS_INS;
          FS_INS: if (byte_done) begin
            cls       <= ins_cls;
            cmd_dr    <= byte_val[3:2];
            cmd_wiper <= byte_val[0];
            if (is_xfer(ins_cls)) begin
              cmd_valid <= 1'b1;
              cmd_kind  <= kind_of(ins_cls);
              state     <= FS_DONE;
            end else if (ins_cls == OC_STEP) begin
              state <= FS_STEP;
            end else if (ins_cls == OC_NONE) begin
              state <= FS_DONE;
            end else begin
              state <= FS_DATA;
            end
          end
          FS_DATA: if (byte_done) begin
            if (is_write(cls)) begin
              cmd_valid <= 1'b1;
              cmd_kind  <= kind_of(cls);
              cmd_data  <= byte_val[DW-1:0];
            end
            state <= FS_DONE;
          end
          FS_STEP: begin
            cmd_valid <= 1'b1;
            cmd_kind  <= CK_STEP;
            cmd_up    <= si_q;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/scf_tx.sv
module scf_tx #(
  parameter int BW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_q,
  input  logic                  fall_evt,
  input  logic                  in_read,
  input  logic [$clog2(BW)-1:0] bit_idx,
  input  logic [BW-1:0]         word,
  output logic                  so_bit,
  output logic                  so_oe
);
  logic [BW-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      so_bit <= 1'b0;
      so_oe  <= 1'b0;
    end else if (cs_q) begin
      sh     <= '0;
      so_bit <= 1'b0;
      so_oe  <= 1'b0;
    end else if (fall_evt) begin
      if (in_read) begin
        so_oe <= 1'b1;
        if (bit_idx == '0) begin
          so_bit <= word[BW-1];
          sh     <= word << 1;
        end else begin
          so_bit <= sh[BW-1];
          sh     <= sh << 1;
        end
      end else begin
        so_oe  <= 1'b0;
        so_bit <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/scf_frame_decoder.sv
module scf_frame_decoder #(
  parameter int         DW      = 6,
  parameter logic [3:0] ID_CODE = 4'b0101
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          cs_n,
  input  logic          si,
  input  logic [1:0]    dev_addr,
  input  logic [DW-1:0] rd_data,
  input  logic          wr_busy,
  output logic          so_bit,
  output logic          so_oe,
  output logic          cmd_valid,
  output logic [2:0]    cmd_kind,
  output logic [1:0]    cmd_dr,
  output logic          cmd_wiper,
  output logic [DW-1:0] cmd_data,
  output logic          cmd_up,
  output logic          rd_from_dr
);
  localparam int BW = 8;
  localparam int CW = $clog2(BW);

  logic          cs_q, si_q, rise_evt, fall_evt;
  logic          byte_done, in_read, rd_status, id_fail;
  logic [BW-1:0] byte_val, tx_word;
  logic [CW-1:0] bit_idx;

  scf_pin_sync u_sync (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .cs_q(cs_q), .si_q(si_q), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  scf_rx #(.BW(BW)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .si_q(si_q), .rise_evt(rise_evt),
    .byte_done(byte_done), .byte_val(byte_val), .bit_idx(bit_idx)
  );

  scf_ctrl #(.DW(DW), .BW(BW), .ID_CODE(ID_CODE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .si_q(si_q), .rise_evt(rise_evt),
    .byte_done(byte_done), .byte_val(byte_val), .dev_addr(dev_addr),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_dr(cmd_dr),
    .cmd_wiper(cmd_wiper), .cmd_data(cmd_data), .cmd_up(cmd_up),
    .in_read(in_read), .rd_from_dr(rd_from_dr), .rd_status(rd_status),
    .id_fail(id_fail)
  );

  assign tx_word = rd_status ? {{(BW-1){1'b0}}, wr_busy}
                             : {{(BW-DW){1'b0}}, rd_data};

  scf_tx #(.BW(BW)) u_tx (
    .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .fall_evt(fall_evt),
    .in_read(in_read), .bit_idx(bit_idx), .word(tx_word),
    .so_bit(so_bit), .so_oe(so_oe)
  );
endmodule

// File: rtl/scf_frame_chk.sv
module scf_frame_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_q,
  input logic       fall_evt,
  input logic       id_fail,
  input logic       in_read,
  input logic       cmd_valid,
  input logic [2:0] cmd_kind,
  input logic       so_oe,
  input logic       so_bit
);
  // R9
  cmd_while_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !$past(cs_q));

  // R8
  oe_rise_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_oe) |-> in_read);

  // R8
  quiet_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !so_oe |-> !so_bit);

  // R6
  so_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(fall_evt) && !$past(cs_q)) |-> $stable(so_bit));

  // R2
  id_fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_fail |=> !so_oe);

  // R5
  single_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind != 3'd6) |=> !cmd_valid);
endmodule

bind scf_frame_decoder scf_frame_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .fall_evt(fall_evt),
  .id_fail(id_fail), .in_read(in_read), .cmd_valid(cmd_valid),
  .cmd_kind(cmd_kind), .so_oe(so_oe), .so_bit(so_bit)
);

// File: tb/tb_scf_frame_decoder.sv
module tb_scf_frame_decoder;
  localparam int HALF = 4;
  localparam int LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic [1:0] dev_addr = 2'd0;
  logic       wr_busy = 1'b0;
  logic [5:0] rd_data;
  logic       so_bit, so_oe, cmd_valid, cmd_wiper, cmd_up, rd_from_dr;
  logic [2:0] cmd_kind;
  logic [1:0] cmd_dr;
  logic [5:0] cmd_data;

  int n_checks = 0, n_fails = 0, cycles = 0;
  int n_cmd = 0, n_up = 0;
  logic [2:0] last_kind;
  logic [5:0] last_data;
  logic [1:0] last_dr;
  logic       last_w;
  logic [7:0] rx2;
  logic       oe01, oe2;

  always #5 clk = ~clk;

  // bank model
  assign rd_data = rd_from_dr ? {2'b10, cmd_dr, 1'b0, cmd_wiper} : {5'b01101, cmd_wiper};

  scf_frame_decoder dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .dev_addr(dev_addr), .rd_data(rd_data), .wr_busy(wr_busy),
    .so_bit(so_bit), .so_oe(so_oe), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_dr(cmd_dr), .cmd_wiper(cmd_wiper), .cmd_data(cmd_data),
    .cmd_up(cmd_up), .rd_from_dr(rd_from_dr)
  );

  always @(posedge clk) begin
    if (rst_n && cmd_valid) begin
      n_cmd     <= n_cmd + 1;
      n_up      <= n_up + int'(cmd_up);
      last_kind <= cmd_kind;
      last_data <= cmd_data;
      last_dr   <= cmd_dr;
      last_w    <= cmd_wiper;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb,
                           output logic [7:0] rx, output logic oe_any);
    rx = 8'h00;
    oe_any = 1'b0;
    for (int i = 7; i > 7 - nb; i--) begin
      si = b[i];
      repeat (HALF) @(negedge clk);
      rx[i] = so_bit;
      oe_any = oe_any | so_oe;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  // nb2: bits of the third byte sent (0 = two-byte frame); nb1 likewise for the second byte
  task automatic frame(input logic [7:0] b0, input logic [7:0] b1, input int nb1,
                       input logic [7:0] b2, input int nb2);
    logic [7:0] r;
    logic o0, o1;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    send_bits(b0, 8, r, o0);
    send_bits(b1, nb1, r, o1);
    oe01 = o0 | o1;
    rx2 = 8'h00;
    oe2 = 1'b0;
    if (nb2 > 0) send_bits(b2, nb2, rx2, oe2);
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > LIMIT) begin
        n_fails++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, LIMIT);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
      end
    end
  end

  initial begin
    int c0, u0;
    logic [7:0] exp_rx;
    int exp_n, exp_k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!so_oe && !cmd_valid, "reset R8", {so_oe, cmd_valid}, 0);

    // R1: every identification address against every strapping
    for (int p = 0; p < 4; p++) begin
      dev_addr = 2'(p);
      for (int a = 0; a < 4; a++) begin
        c0 = n_cmd;
        frame({4'b0101, 2'b00, 2'(a)}, 8'hD0, 8, 8'h00, 0);
        chk((n_cmd - c0) == (a == p ? 1 : 0), "R1 address gate", n_cmd - c0, a == p ? 1 : 0);
      end
    end
    dev_addr = 2'd2;

    // R2: wrong type nibble / nonzero bits 3:2, followed by a read instruction
    c0 = n_cmd;
    frame(8'h62, 8'h91, 8, 8'h00, 8);
    chk(n_cmd == c0 && !oe01 && !oe2, "R2 bad nibble", n_cmd - c0, 0);
    c0 = n_cmd;
    frame(8'h56, 8'hC0, 8, 8'h15, 8);
    chk(n_cmd == c0 && !oe2, "R2 bits 3:2", n_cmd - c0, 0);

    // opcode sweep: dr=2, wiper=1, third byte E5
    wr_busy = 1'b1;
    for (int op = 0; op < 16; op++) begin
      c0 = n_cmd;
      u0 = n_up;
      frame(8'h52, {4'(op), 2'b10, 1'b0, 1'b1}, 8, 8'hE5, 8);
      exp_n = 0; exp_k = 0; exp_rx = 8'h00;
      case (op)
        4'hA: begin exp_n = 1; exp_k = 0; end
        4'hC: begin exp_n = 1; exp_k = 1; end
        4'hD: begin exp_n = 1; exp_k = 2; end
        4'hE: begin exp_n = 1; exp_k = 3; end
        4'h1: begin exp_n = 1; exp_k = 4; end
        4'h8: begin exp_n = 1; exp_k = 5; end
        4'h2: begin exp_n = 8; exp_k = 6; end
        4'h9: exp_rx = 8'h1B;
        4'hB: exp_rx = 8'h29;
        4'h5: exp_rx = 8'h01;
        default: ;
      endcase
      chk((n_cmd - c0) == exp_n, "R4 R5 R10 R11 command count", n_cmd - c0, exp_n);
      if (exp_n > 0) begin
        chk(int'(last_kind) == exp_k, "R4 R5 R11 kind", last_kind, exp_k);
        chk(last_dr == 2'd2 && last_w, "R3 operands", {last_dr, last_w}, 5);
      end
      if (op == 4'hA || op == 4'hC)
        chk(last_data == 6'h25, "R4 data low bits", last_data, 6'h25);
      if (op == 4'h2)
        chk((n_up - u0) == 5, "R11 up count", n_up - u0, 5);
      chk(!oe01, "R8 oe in early bytes", oe01, 0);
      chk(oe2 == (op == 9 || op == 11 || op == 5), "R8 R10 oe in third byte", oe2,
          (op == 9 || op == 11 || op == 5));
      if (op == 9 || op == 11 || op == 5)
        chk(rx2 == exp_rx, "R6 R7 read value", rx2, exp_rx);
      chk(!so_oe, "R8 oe after frame", so_oe, 0);
    end

    // R7: status with busy clear
    wr_busy = 1'b0;
    frame(8'h52, 8'h51, 8, 8'h00, 8);
    chk(rx2 == 8'h00 && oe2, "R7 status idle", rx2, 0);

    // R6: wiper 0 read, data register 1 read
    frame(8'h52, 8'h90, 8, 8'h00, 8);
    chk(rx2 == 8'h1A, "R6 wiper0 read", rx2, 8'h1A);
    frame(8'h52, 8'hB4, 8, 8'h00, 8);
    chk(rx2 == 8'h24, "R6 dreg1 read", rx2, 8'h24);

    // R4: upper bits ignored
    c0 = n_cmd;
    frame(8'h52, 8'hA1, 8, 8'hFF, 8);
    chk(n_cmd - c0 == 1 && last_data == 6'h3F, "R4 upper bits", last_data, 6'h3F);
    c0 = n_cmd;
    frame(8'h52, 8'hC8, 8, 8'h80, 8);
    chk(n_cmd - c0 == 1 && last_data == 6'h00 && last_dr == 2'd2, "R4 zero data", last_data, 0);

    // R3: bit 1 set
    c0 = n_cmd;
    frame(8'h52, 8'hA2, 8, 8'h11, 8);
    chk(n_cmd == c0, "R3 bit1 set", n_cmd - c0, 0);

    // R9: aborted third byte and aborted instruction byte
    c0 = n_cmd;
    frame(8'h52, 8'hC4, 8, 8'h2A, 5);
    chk(n_cmd == c0, "R9 abort data byte", n_cmd - c0, 0);
    c0 = n_cmd;
    frame(8'h52, 8'hD0, 6, 8'h00, 0);
    chk(n_cmd == c0, "R9 abort instruction byte", n_cmd - c0, 0);

    // R5: trailing bytes after transfer ignored
    c0 = n_cmd;
    frame(8'h52, 8'hE4, 8, 8'hFF, 8);
    chk(n_cmd - c0 == 1 && !oe2, "R5 trailing ignored", n_cmd - c0, 1);

    // R11: step pattern 0F
    c0 = n_cmd;
    u0 = n_up;
    frame(8'h52, 8'h20, 8, 8'h0F, 8);
    chk(n_cmd - c0 == 8 && n_up - u0 == 4, "R11 step pattern", n_up - u0, 4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule